// File: doc/BRIEF.md
# Analog Multiplexer Address Sequencer

This block drives the channel-select lines and the start strobe of a wide analog input multiplexer that feeds a 12-bit converter. It supports 1000 channels. Channels 0 to 499 form the low-level bank and channels 500 to 999 form the high-level bank. Software starts a run in one of three addressing modes:

- **Random:** each request converts the channel named by an external binary word.
- **Sequential:** the block sweeps a fixed window of channels. A programmable divider of the system clock paces it, or a synchronised external pace input does.
- **Dwell:** the block converts one fixed channel over and over.

For every sample the block issues one address strobe and then waits for the converter's done signal. It then captures the 12-bit result, its sign bit and the overscale flag, tagged with the channel it came from, and pulses data-ready. A stop command ends the run only after any conversion already in flight has delivered its result.

Top module: `mux_addr_seq`

## Requirements
- R1: After reset, `busy`, `addr_strobe`, `res_ready`, `ch_high` are 0 and `ch_addr` is 0.
- R2: `cmd_start` is acted on only while idle, and only with a valid configuration. The mode codes are 00 random, 01 sequential and 10 dwell; code 11 is invalid. In sequential mode `seq_first` must be at most 999, and in dwell mode `dwell_ch` must be at most 999. Any other start, including a start while busy, has no effect.
- R3: In random mode, a `rand_req` pulse while armed produces one strobe addressing `rand_ch`. A request with `rand_ch` at 1000 or above produces no strobe.
- R4: In sequential mode the addresses run `seq_first`, `seq_first+1` and so on. After the address equal to `seq_last`, or after 999, whichever comes first, the sequence returns to `seq_first`.
- R5: With internal pacing (`ext_sel`=0) and a converter that keeps up, consecutive sequential strobes are exactly `div_limit+1` clock cycles apart.
- R6: With external pacing (`ext_sel`=1), each rising edge of `ext_pace` produces one strobe. The internal divider causes no strobes.
- R7: In dwell mode every strobe addresses the `dwell_ch` value captured at start, and a new strobe follows each returned result.
- R8: `ch_high` is 1 exactly when `ch_addr` is 500 or greater, and it is valid together with `addr_strobe`.
- R9: A `conv_done` while a sample is outstanding makes `res_ready` pulse for one cycle, in the cycle after the done. At that point:
  - `res_data` equals `conv_data`;
  - `res_sign` equals its bit 11;
  - `res_ovr` equals `conv_ovr`;
  - `res_addr` equals the strobed channel.
- R10: A `cmd_stop` issued during an outstanding conversion lets that result be delivered and then returns the block to idle. A stop while armed returns it to idle with no further strobe.
- R11: At most one sample is outstanding. A second strobe never follows before the previous result has returned, and pace ticks that arrive during a conversion are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse; latches mode and channel settings |
| cmd_stop | input | 1 | Stop pulse |
| mode_sel | input | 2 | Mode code: 00 random, 01 sequential, 10 dwell |
| seq_first | input | 10 | First channel of sequential window |
| seq_last | input | 10 | Last channel of sequential window |
| dwell_ch | input | 10 | Channel held in dwell mode |
| rand_ch | input | 10 | Externally supplied channel for random mode |
| rand_req | input | 1 | Request one random-mode sample |
| ext_sel | input | 1 | Pacing source: 0 internal divider, 1 external input |
| div_limit | input | 16 | Internal pace period minus one, in clocks |
| ext_pace | input | 1 | Asynchronous external pace input |
| conv_done | input | 1 | Converter finished |
| conv_data | input | 12 | Converter result, bit 11 is sign |
| conv_ovr | input | 1 | Converter overscale flag |
| busy | output | 1 | A run is active |
| ch_addr | output | 10 | Multiplexer channel address |
| ch_high | output | 1 | Address lies in the high-level bank |
| addr_strobe | output | 1 | One-cycle sample start with valid address |
| res_data | output | 12 | Captured result |
| res_sign | output | 1 | Sign bit of captured result |
| res_ovr | output | 1 | Captured overscale flag |
| res_addr | output | 10 | Channel the captured result belongs to |
| res_ready | output | 1 | One-cycle result-ready pulse |

## Verification
The embedded properties check the following on every cycle:
- the bank flag stays consistent with the strobed address;
- strobes stay within the channel range and never appear while idle;
- two strobes are never back to back;
- each ready pulse is preceded by a converter done;
- the sequential pointer never leaves the channel range.

The bench scenarios are needed for the behaviours that depend on history:
- the exact address order, including both wrap cases;
- the cycle spacing set by the divider;
- the dropping of ignored starts and out-of-range random words;
- pacing by external edges alone;
- the orderly finish of a stop issued during a conversion.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [1:0] {
    MODE_RAND  = 2'b00,
    MODE_SEQ   = 2'b01,
    MODE_DWELL = 2'b10,
    MODE_BAD   = 2'b11
  } seq_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_WAIT  = 2'b10
  } seq_state_t;
endpackage

// File: rtl/mseq_pace.sv
module mseq_pace #(
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_limit,
  input  logic             ext_pace,
  output logic             tick
);
  logic [DIV_W-1:0]  cnt;
  logic              int_tick;
  logic [SYNC_N-1:0] sync_q;
  logic              ext_prev;
  logic              ext_tick;

  // internal divider: one tick every div_limit+1 cycles while running
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      int_tick <= 1'b0;
    end else if (cnt >= div_limit) begin
      cnt      <= '0;
      int_tick <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      int_tick <= 1'b0;
    end
  end

  // external input: synchroniser chain then rising-edge detect
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_N-2:0], ext_pace};
      ext_prev <= sync_q[SYNC_N-1];
    end
  end

  assign ext_tick = run & sync_q[SYNC_N-1] & ~ext_prev;
  assign tick     = ext_sel ? ext_tick : int_tick;

  // R5: the internal tick is never set while the divider is stopped
  p_int_tick_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> !int_tick);
endmodule

// File: rtl/mseq_addr.sv
module mseq_addr
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NUM_CH = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  seq_mode_t         mode_in,
  input  seq_mode_t         run_mode,
  input  logic [ADDR_W-1:0] seq_first,
  input  logic [ADDR_W-1:0] seq_last,
  input  logic [ADDR_W-1:0] dwell_ch,
  input  logic [ADDR_W-1:0] rand_ch,
  input  logic              advance,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              cfg_ok,
  output logic              rand_ok
);
  localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

  logic [ADDR_W-1:0] first_q, last_q, dwell_q, next_seq;
  logic              wrap;

  always_comb begin
    unique case (mode_in)
      MODE_RAND:  cfg_ok = 1'b1;
      MODE_SEQ:   cfg_ok = (seq_first <= LAST_CH);
      MODE_DWELL: cfg_ok = (dwell_ch <= LAST_CH);
      default:    cfg_ok = 1'b0;
    endcase
  end

  assign rand_ok = (rand_ch <= LAST_CH);
  assign wrap    = (next_seq == last_q) || (next_seq == LAST_CH);

  always_comb begin
    unique case (run_mode)
      MODE_RAND:  sel_addr = rand_ch;
      MODE_SEQ:   sel_addr = next_seq;
      MODE_DWELL: sel_addr = dwell_q;
      default:    sel_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      last_q   <= '0;
      dwell_q  <= '0;
      next_seq <= '0;
    end else if (load) begin
      first_q  <= seq_first;
      last_q   <= seq_last;
      dwell_q  <= dwell_ch;
      next_seq <= seq_first;
    end else if (advance && run_mode == MODE_SEQ) begin
      next_seq <= wrap ? first_q : next_seq + 1'b1;
    end
  end

  // R4: the sequential pointer stays within the channel range
  p_seq_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (run_mode == MODE_SEQ) |-> (next_seq <= LAST_CH));
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12,
  parameter int NUM_CH = 1000,
  parameter int LOW_CH = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  seq_mode_t         mode_sel,
  input  logic              cfg_ok,
  input  logic              rand_req,
  input  logic              rand_ok,
  input  logic              tick,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_ovr,
  output seq_mode_t         run_mode,
  output logic              load,
  output logic              advance,
  output logic              run,
  output logic              busy,
  output logic [ADDR_W-1:0] ch_addr,
  output logic              ch_high,
  output logic              addr_strobe,
  output logic [DATA_W-1:0] res_data,
  output logic              res_sign,
  output logic              res_ovr,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_ready
);
  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(LOW_CH);
  localparam logic [ADDR_W-1:0] LAST_CH   = ADDR_W'(NUM_CH - 1);

  seq_state_t state;
  logic       stop_pend;
  logic       stop_now;
  logic       trigger;

  assign stop_now = cmd_stop | stop_pend;
  assign load     = (state == ST_IDLE) & cmd_start & cfg_ok;
  assign busy     = (state != ST_IDLE);
  assign run      = busy;

  always_comb begin
    trigger = 1'b0;
    if (state == ST_ARMED && !stop_now) begin
      unique case (run_mode)
        MODE_RAND:  trigger = rand_req & rand_ok;
        MODE_SEQ:   trigger = tick;
        MODE_DWELL: trigger = 1'b1;
        default:    trigger = 1'b0;
      endcase
    end
  end
  assign advance = trigger;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      run_mode    <= MODE_RAND;
      stop_pend   <= 1'b0;
      ch_addr     <= '0;
      ch_high     <= 1'b0;
      addr_strobe <= 1'b0;
      res_data    <= '0;
      res_sign    <= 1'b0;
      res_ovr     <= 1'b0;
      res_addr    <= '0;
      res_ready   <= 1'b0;
    end else begin
      addr_strobe <= 1'b0;
      res_ready   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (load) begin
            run_mode <= mode_sel;
            state    <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (stop_now) begin
            stop_pend <= 1'b0;
            state     <= ST_IDLE;
          end else if (trigger) begin
            ch_addr     <= sel_addr;
            ch_high     <= (sel_addr >= HIGH_BASE);
            addr_strobe <= 1'b1;
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cmd_stop) stop_pend <= 1'b1;
          if (conv_done) begin
            res_data  <= conv_data;
            res_sign  <= conv_data[DATA_W-1];
            res_ovr   <= conv_ovr;
            res_addr  <= ch_addr;
            res_ready <= 1'b1;
            if (stop_now) begin
              stop_pend <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              state <= ST_ARMED;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a ready pulse is always the answer to a converter done
  p_ready_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    res_ready |-> $past(conv_done));
  // R8: bank flag agrees with the address it travels with
  p_bank_match_r8: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> (ch_high == (ch_addr >= HIGH_BASE)));
  // R3: a strobed address is always a real channel
  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> (ch_addr <= LAST_CH));
  // R11: never two strobes in a row
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |=> !addr_strobe);
  // R10: no strobe while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !addr_strobe);
  // R7: a dwell result belongs to the channel still on the address lines
  p_dwell_same_r7: assert property (@(posedge clk) disable iff (rst)
    (res_ready && run_mode == MODE_DWELL) |-> (res_addr == ch_addr));
endmodule

// File: rtl/mux_addr_seq.sv
module mux_addr_seq
  import mseq_pkg::*;
#(
  parameter int NUM_CH = 1000,
  parameter int LOW_CH = 500,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12,
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] seq_first,
  input  logic [ADDR_W-1:0] seq_last,
  input  logic [ADDR_W-1:0] dwell_ch,
  input  logic [ADDR_W-1:0] rand_ch,
  input  logic              rand_req,
  input  logic              ext_sel,
  input  logic [DIV_W-1:0]  div_limit,
  input  logic              ext_pace,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_ovr,
  output logic              busy,
  output logic [ADDR_W-1:0] ch_addr,
  output logic              ch_high,
  output logic              addr_strobe,
  output logic [DATA_W-1:0] res_data,
  output logic              res_sign,
  output logic              res_ovr,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_ready
);
  seq_mode_t         mode_in, run_mode;
  logic              load, advance, run, tick, cfg_ok, rand_ok;
  logic [ADDR_W-1:0] sel_addr;

  assign mode_in = seq_mode_t'(mode_sel);

  mseq_pace #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_pace (
    .clk(clk), .rst(rst), .run(run), .ext_sel(ext_sel),
    .div_limit(div_limit), .ext_pace(ext_pace), .tick(tick)
  );

  mseq_addr #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_addr (
    .clk(clk), .rst(rst), .load(load), .mode_in(mode_in), .run_mode(run_mode),
    .seq_first(seq_first), .seq_last(seq_last), .dwell_ch(dwell_ch),
    .rand_ch(rand_ch), .advance(advance), .sel_addr(sel_addr),
    .cfg_ok(cfg_ok), .rand_ok(rand_ok)
  );

  mseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .LOW_CH(LOW_CH)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .mode_sel(mode_in), .cfg_ok(cfg_ok), .rand_req(rand_req), .rand_ok(rand_ok),
    .tick(tick), .sel_addr(sel_addr), .conv_done(conv_done),
    .conv_data(conv_data), .conv_ovr(conv_ovr), .run_mode(run_mode),
    .load(load), .advance(advance), .run(run), .busy(busy),
    .ch_addr(ch_addr), .ch_high(ch_high), .addr_strobe(addr_strobe),
    .res_data(res_data), .res_sign(res_sign), .res_ovr(res_ovr),
    .res_addr(res_addr), .res_ready(res_ready)
  );
endmodule

// File: tb/tb_mux_addr_seq.sv
module tb_mux_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [9:0]  seq_first = '0, seq_last = '0, dwell_ch = '0, rand_ch = '0;
  logic        rand_req = 1'b0, ext_sel = 1'b0, ext_pace = 1'b0;
  logic [15:0] div_limit = 16'd7;
  logic        conv_done = 1'b0, conv_ovr = 1'b0;
  logic [11:0] conv_data = '0;
  logic        busy, ch_high, addr_strobe, res_sign, res_ovr, res_ready;
  logic [9:0]  ch_addr, res_addr;
  logic [11:0] res_data;

  mux_addr_seq dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .mode_sel(mode_sel), .seq_first(seq_first), .seq_last(seq_last),
    .dwell_ch(dwell_ch), .rand_ch(rand_ch), .rand_req(rand_req),
    .ext_sel(ext_sel), .div_limit(div_limit), .ext_pace(ext_pace),
    .conv_done(conv_done), .conv_data(conv_data), .conv_ovr(conv_ovr),
    .busy(busy), .ch_addr(ch_addr), .ch_high(ch_high), .addr_strobe(addr_strobe),
    .res_data(res_data), .res_sign(res_sign), .res_ovr(res_ovr),
    .res_addr(res_addr), .res_ready(res_ready)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, ns = 0, nr = 0;
  int s_addr [0:511];
  int s_high [0:511];
  int s_cyc  [0:511];
  int r_addr [0:511];
  int r_data [0:511];
  int r_sign [0:511];
  int r_ovr  [0:511];

  function automatic int conv_val(int a);
    return (a * 37 + 5) % 4096;
  endfunction
  function automatic int conv_flag(int a);
    return (a % 5 == 0) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: answer each strobe three cycles later
  initial begin
    int a;
    forever begin
      @(negedge clk);
      if (addr_strobe) begin
        a = int'(ch_addr);
        @(negedge clk);
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = 12'(conv_val(a));
        conv_ovr  = conv_flag(a) != 0;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (addr_strobe && ns < 512) begin
        s_addr[ns] = int'(ch_addr); s_high[ns] = int'(ch_high); s_cyc[ns] = cyc; ns++;
      end
      if (res_ready && nr < 512) begin
        r_addr[nr] = int'(res_addr); r_data[nr] = int'(res_data);
        r_sign[nr] = int'(res_sign); r_ovr[nr] = int'(res_ovr); nr++;
      end
    end
  end

  // watchdog
  initial begin
    #(5 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic start_run(input logic [1:0] m);
    @(negedge clk); mode_sel = m; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_strobes(input int target, input int limit);
    for (int i = 0; i < limit && ns < target; i++) @(negedge clk);
  endtask

  task automatic check_results(input int rb, input int re, input string tag);
    for (int i = rb; i < re; i++) begin
      chk(r_data[i] == conv_val(r_addr[i]), tag, r_data[i], conv_val(r_addr[i]));
      chk(r_sign[i] == (conv_val(r_addr[i]) >> 11), tag, r_sign[i], conv_val(r_addr[i]) >> 11);
      chk(r_ovr[i] == conv_flag(r_addr[i]), tag, r_ovr[i], conv_flag(r_addr[i]));
    end
  endtask

  initial begin
    int sb, rb, e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(addr_strobe == 0, "R1 strobe", addr_strobe, 0);
    chk(res_ready == 0, "R1 ready", res_ready, 0);
    chk(ch_addr == 0 && ch_high == 0, "R1 addr", ch_addr, 0);

    // R2 invalid starts
    start_run(2'b11); @(negedge clk);
    chk(busy == 0, "R2 mode 11", busy, 0);
    dwell_ch = 10'd1000; start_run(2'b10); @(negedge clk);
    chk(busy == 0, "R2 dwell out of range", busy, 0);
    seq_first = 10'd1005; start_run(2'b01); @(negedge clk);
    chk(busy == 0, "R2 seq first out of range", busy, 0);

    // R4/R5/R8/R9 sequential window crossing the bank boundary
    sb = ns; rb = nr;
    seq_first = 10'd495; seq_last = 10'd504; div_limit = 16'd7; ext_sel = 1'b0;
    start_run(2'b01);
    chk(busy == 1, "R2 valid start", busy, 1);
    wait_strobes(sb + 5, 400);
    // R2: a start while busy is ignored
    dwell_ch = 10'd7; start_run(2'b10);
    wait_strobes(sb + 25, 800);
    stop_run();
    chk(busy == 0, "R10 idle after stop", busy, 0);
    chk(nr - rb == ns - sb, "R10 in-flight result delivered", nr - rb, ns - sb);
    for (int k = 0; k < 25; k++) begin
      e = 495 + (k % 10);
      chk(s_addr[sb + k] == e, "R4 R2 sequence", s_addr[sb + k], e);
      chk(s_high[sb + k] == (e >= 500 ? 1 : 0), "R8 bank", s_high[sb + k], e >= 500 ? 1 : 0);
      if (k > 0)
        chk(s_cyc[sb + k] - s_cyc[sb + k - 1] == 8, "R5 spacing",
            s_cyc[sb + k] - s_cyc[sb + k - 1], 8);
    end
    for (int k = 0; k < nr - rb; k++)
      chk(r_addr[rb + k] == s_addr[sb + k], "R9 result addr", r_addr[rb + k], s_addr[sb + k]);
    check_results(rb, nr, "R9 result");

    // R4 wrap at the last channel when first > last
    sb = ns;
    seq_first = 10'd997; seq_last = 10'd3; div_limit = 16'd5;
    start_run(2'b01);
    wait_strobes(sb + 7, 300);
    stop_run();
    for (int k = 0; k < 7; k++) begin
      e = 997 + (k % 3);
      chk(s_addr[sb + k] == e, "R4 wrap at 999", s_addr[sb + k], e);
    end

    // R10 stop while armed, before any tick
    sb = ns; div_limit = 16'd60; seq_first = 10'd20; seq_last = 10'd30;
    start_run(2'b01);
    repeat (4) @(negedge clk);
    stop_run();
    repeat (80) @(negedge clk);
    chk(ns == sb, "R10 stop while armed", ns - sb, 0);
    chk(busy == 0, "R10 idle", busy, 1'b0);

    // R3 random mode
    sb = ns; rb = nr;
    start_run(2'b00);
    begin
      int vals [0:6] = '{0, 499, 500, 999, 1000, 1023, 321};
      int got;
      for (int i = 0; i < 7; i++) begin
        got = ns;
        @(negedge clk); rand_ch = 10'(vals[i]); rand_req = 1'b1;
        @(negedge clk); rand_req = 1'b0;
        repeat (10) @(negedge clk);
        if (vals[i] < 1000) begin
          chk(ns == got + 1, "R3 one strobe", ns - got, 1);
          chk(s_addr[got] == vals[i], "R3 address", s_addr[got], vals[i]);
          chk(s_high[got] == (vals[i] >= 500 ? 1 : 0), "R8 random bank", s_high[got],
              vals[i] >= 500 ? 1 : 0);
        end else begin
          chk(ns == got, "R3 out-of-range ignored", ns - got, 0);
        end
      end
    end
    stop_run();
    check_results(rb, nr, "R9 random result");

    // R7 dwell
    sb = ns; rb = nr; dwell_ch = 10'd777;
    start_run(2'b10);
    dwell_ch = 10'd5;
    wait_strobes(sb + 10, 200);
    stop_run();
    for (int k = 0; k < 10; k++)
      chk(s_addr[sb + k] == 777, "R7 dwell channel", s_addr[sb + k], 777);
    for (int k = 1; k < 10; k++)
      chk(s_cyc[sb + k] - s_cyc[sb + k - 1] == 4, "R7 R11 continuous",
          s_cyc[sb + k] - s_cyc[sb + k - 1], 4);
    check_results(rb, nr, "R9 dwell result");

    // R6 external pacing
    sb = ns; ext_sel = 1'b1; div_limit = 16'd1; seq_first = 10'd10; seq_last = 10'd12;
    start_run(2'b01);
    repeat (100) @(negedge clk);
    chk(ns == sb, "R6 divider inert", ns - sb, 0);
    for (int p = 0; p < 4; p++) begin
      ext_pace = 1'b1; repeat (3) @(negedge clk);
      ext_pace = 1'b0; repeat (12) @(negedge clk);
    end
    chk(ns - sb == 4, "R6 one strobe per edge", ns - sb, 4);
    for (int k = 0; k < 4; k++)
      chk(s_addr[sb + k] == 10 + (k % 3), "R6 R4 ext sequence", s_addr[sb + k], 10 + (k % 3));
    stop_run();
    ext_sel = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule